// File: doc/BRIEF.md
# Branch-Predicted Fetch Address Selector

This block picks the address of the next instruction fetch in a front end that fetches one aligned group of instructions per cycle. The current fetch address drives the instruction cache request and, in the same cycle, a direct-mapped branch target buffer and a table of two-bit direction counters. A target buffer hit means the group holds a branch at a recorded slot, and gives that branch's target. If the counter for the group says taken, the next fetch starts at the target. The slots after the branch are also dropped from the valid mask sent to decode. Otherwise fetch moves on to the sequential address that follows the group.

The back end trains the predictor through an update port that accepts one resolved branch per cycle. It can also force a corrected address through a redirect input, and the redirect wins over any prediction. While the cache response is not valid, the fetch address holds and no slot is marked valid.

Top module: `fetch_addr_sel`

## Requirements
- R1: After reset the fetch address is RESET_PC, every target buffer entry is invalid and every direction counter holds 1 (weakly not taken).
- R2: On a target buffer miss with a valid cache response, next_pc is the fetch address plus 4*GROUP (16 by default), slot_mask is all ones and pred_taken is 0. The fetch address takes that value on the next clock edge.
- R3: On a hit whose counter is 2 or 3, pred_taken is 1, next_pc is the stored target, and slot_mask has ones exactly in bit positions 0 up to the stored slot. The fetch address becomes the target on the next edge.
- R4: On a hit whose counter is 0 or 1, pred_taken is 0, next_pc is the fall-through address and slot_mask is all ones.
- R5: Each update moves the counter of the group containing upd_pc up by one when taken and down by one when not taken. The counter saturates at 3 and 0.
- R6: The buffer is indexed by fetch address bits [7:4] and tagged by bits [31:8]. An address that shares an index with a stored entry but has a different tag is a miss.
- R7: When redirect_valid is high, the fetch address equals redirect_pc after the next edge, whatever the prediction and the cache response.
- R8: When icache_rsp_valid is low and there is no redirect, slot_mask is 0, next_pc equals the fetch address and the fetch address holds.
- R9: An update writes the buffer entry for upd_pc with valid set, the tag, upd_target and upd_slot, whatever the outcome. The update also trains the counter indexed by bits [9:4]. Lookups see both changes from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| redirect_valid | input | 1 | Back-end correction request |
| redirect_pc | input | 32 | Corrected fetch address |
| icache_req_addr | output | 32 | Current fetch address sent to the cache |
| icache_rsp_valid | input | 1 | Cache returned the group this cycle |
| next_pc | output | 32 | Address the next fetch will use |
| slot_mask | output | 4 | Valid slots of the current group |
| pred_taken | output | 1 | A taken branch was predicted in the group |
| upd_valid | input | 1 | Resolved branch update present |
| upd_pc | input | 32 | Group address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 32 | Resolved target |
| upd_slot | input | 2 | Slot of the branch within its group |

## Verification
next_pc, slot_mask and pred_taken are combinational from the fetch address register and the tables, so they are due in the same cycle as a change of icache_rsp_valid. The bench raises that input and samples 1 ns later, well before the next edge. The fetch address register and the tables change one edge after a redirect, an accepted fetch or an update. So the bench drives inputs at the falling edge and checks only after the following rising edge has passed. A sweep over all sixteen buffer indices walks each counter through every state, with the taken slot varied. The bench compares each result with values worked out from the index, tag and counter arithmetic in the requirements.

// File: rtl/fab_pkg.sv
// Package fab_pkg: shared types and helpers of the fetch address selector.
// Assumes two-bit direction counters; the upper bit is the prediction.
package fab_pkg;
    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr_t;

    // Saturating step of a direction counter toward the resolved outcome.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t res;
        res = cur;
        if (taken && cur != CTR_STRONG_T)
            res = ctr_t'(cur + 2'd1);
        else if (!taken && cur != CTR_STRONG_NT)
            res = ctr_t'(cur - 2'd1);
        return res;
    endfunction
endpackage

// File: rtl/fab_btb.sv
// Module fab_btb: direct-mapped branch target buffer.
// One lookup port and one write port. Entries are indexed by group address
// bits above the in-group offset and tagged by the remaining upper bits.
// A write in a cycle is visible to lookups from the next cycle.
module fab_btb #(
    parameter int ADDR_W = 32,
    parameter int GROUP  = 4,
    parameter int DEPTH  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        lk_pc,
    output logic                     lk_hit,
    output logic [ADDR_W-1:0]        lk_target,
    output logic [$clog2(GROUP)-1:0] lk_slot,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_pc,
    input  logic [ADDR_W-1:0]        wr_target,
    input  logic [$clog2(GROUP)-1:0] wr_slot
);
    localparam int OFS    = $clog2(GROUP) + 2;
    localparam int IW     = $clog2(DEPTH);
    localparam int TAG_W  = ADDR_W - OFS - IW;
    localparam int SLOT_W = $clog2(GROUP);

    logic              ent_valid [DEPTH];
    logic [TAG_W-1:0]  ent_tag   [DEPTH];
    logic [ADDR_W-1:0] ent_tgt   [DEPTH];
    logic [SLOT_W-1:0] ent_slot  [DEPTH];

    logic [IW-1:0]    lk_idx, wr_idx;
    logic [TAG_W-1:0] lk_tag, wr_tag;
    logic             unused_lo;

    assign lk_idx    = lk_pc[OFS +: IW];
    assign lk_tag    = lk_pc[ADDR_W-1 -: TAG_W];
    assign wr_idx    = wr_pc[OFS +: IW];
    assign wr_tag    = wr_pc[ADDR_W-1 -: TAG_W];
    assign unused_lo = ^{lk_pc[OFS-1:0], wr_pc[OFS-1:0]};

    // Valid bits: cleared by reset, set by every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent_valid[i] <= 1'b0;
        end else if (wr_en) begin
            ent_valid[wr_idx] <= 1'b1;
        end
    end

    // Entry payload: tag, target and slot, written or refreshed on update.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            ent_tag[wr_idx]  <= wr_tag;
            ent_tgt[wr_idx]  <= wr_target;
            ent_slot[wr_idx] <= wr_slot;
        end
    end

    // Lookup: hit on valid entry with matching tag.
    always_comb begin
        lk_hit    = ent_valid[lk_idx] && (ent_tag[lk_idx] == lk_tag);
        lk_target = ent_tgt[lk_idx];
        lk_slot   = ent_slot[lk_idx];
    end

    // R9: a write is seen by a lookup of the same address one cycle later.
    p_write_visible_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (lk_pc[ADDR_W-1:OFS] != $past(wr_pc[ADDR_W-1:OFS])) ||
                  (lk_hit && lk_target == $past(wr_target) && lk_slot == $past(wr_slot)));
endmodule

// File: rtl/fab_pht.sv
// Module fab_pht: table of two-bit saturating direction counters.
// Indexed by group address bits above the in-group offset. Counters reset to
// weakly not taken. One training update per cycle, visible the next cycle.
module fab_pht #(
    parameter int ADDR_W = 32,
    parameter int GROUP  = 4,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_taken,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_pc,
    input  logic              wr_taken
);
    import fab_pkg::*;

    localparam int OFS = $clog2(GROUP) + 2;
    localparam int IW  = $clog2(DEPTH);

    ctr_t          ctr [DEPTH];
    logic [IW-1:0] lk_idx, wr_idx;
    logic          unused_bits;

    assign lk_idx      = lk_pc[OFS +: IW];
    assign wr_idx      = wr_pc[OFS +: IW];
    assign unused_bits = ^{lk_pc[OFS-1:0], wr_pc[OFS-1:0],
                           lk_pc[ADDR_W-1:OFS+IW], wr_pc[ADDR_W-1:OFS+IW]};

    // Counter array: reset to weakly not taken, stepped on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ctr[i] <= CTR_WEAK_NT;
        end else if (wr_en) begin
            ctr[wr_idx] <= ctr_step(ctr[wr_idx], wr_taken);
        end
    end

    // Prediction: upper counter bit.
    assign lk_taken = ctr[lk_idx][1];

    // R5: a taken update of a saturated counter leaves it saturated.
    p_no_wrap_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && ctr[wr_idx] == CTR_STRONG_T) |=> ctr[$past(wr_idx)] == CTR_STRONG_T);
    // R5: a not-taken update of a zero counter leaves it at zero.
    p_no_wrap_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && ctr[wr_idx] == CTR_STRONG_NT) |=> ctr[$past(wr_idx)] == CTR_STRONG_NT);
endmodule

// File: rtl/fab_mask.sv
// Module fab_mask: builds the valid-slot mask of the fetched group.
// All slots are valid unless a taken branch cuts the group after its slot;
// nothing is valid without a cache response.
module fab_mask #(
    parameter int GROUP = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rsp_valid,
    input  logic                     cut,
    input  logic [$clog2(GROUP)-1:0] cut_slot,
    output logic [GROUP-1:0]         mask
);
    // One enable per slot.
    for (genvar g = 0; g < GROUP; g++) begin : g_slot
        assign mask[g] = rsp_valid && (!cut || (g <= int'(cut_slot)));
    end

    // R3: the mask is always a run of ones starting at slot 0.
    p_mask_prefix_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask & (mask + 1'b1)) == '0));
    // R8: no slot is valid without a response.
    p_mask_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> mask == '0);
endmodule

// File: rtl/fetch_addr_sel.sv
// Module fetch_addr_sel: top of the branch-predicted fetch address selector.
// Holds the fetch address, looks up target buffer and direction table in the
// same cycle as the cache request, and picks redirect, target, fall-through
// or hold as the next address. Assumes group-aligned fetch addresses and a
// cache response that arrives in the request cycle.
module fetch_addr_sel #(
    parameter int              ADDR_W    = 32,
    parameter int              GROUP     = 4,
    parameter int              BTB_DEPTH = 16,
    parameter int              PHT_DEPTH = 64,
    parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_0100
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     redirect_valid,
    input  logic [ADDR_W-1:0]        redirect_pc,
    output logic [ADDR_W-1:0]        icache_req_addr,
    input  logic                     icache_rsp_valid,
    output logic [ADDR_W-1:0]        next_pc,
    output logic [GROUP-1:0]         slot_mask,
    output logic                     pred_taken,
    input  logic                     upd_valid,
    input  logic [ADDR_W-1:0]        upd_pc,
    input  logic                     upd_taken,
    input  logic [ADDR_W-1:0]        upd_target,
    input  logic [$clog2(GROUP)-1:0] upd_slot
);
    localparam int SLOT_W = $clog2(GROUP);
    localparam int GSTEP  = 4 * GROUP;

    logic [ADDR_W-1:0] pc_q, pc_d, fall_pc, btb_target;
    logic              btb_hit, dir_taken;
    logic [SLOT_W-1:0] btb_slot;

    assign icache_req_addr = pc_q;
    assign fall_pc         = pc_q + ADDR_W'(GSTEP);

    fab_btb #(.ADDR_W(ADDR_W), .GROUP(GROUP), .DEPTH(BTB_DEPTH)) u_btb (
        .clk(clk), .rst_n(rst_n),
        .lk_pc(pc_q), .lk_hit(btb_hit), .lk_target(btb_target), .lk_slot(btb_slot),
        .wr_en(upd_valid), .wr_pc(upd_pc), .wr_target(upd_target), .wr_slot(upd_slot)
    );

    fab_pht #(.ADDR_W(ADDR_W), .GROUP(GROUP), .DEPTH(PHT_DEPTH)) u_pht (
        .clk(clk), .rst_n(rst_n),
        .lk_pc(pc_q), .lk_taken(dir_taken),
        .wr_en(upd_valid), .wr_pc(upd_pc), .wr_taken(upd_taken)
    );

    assign pred_taken = btb_hit && dir_taken;

    fab_mask #(.GROUP(GROUP)) u_mask (
        .clk(clk), .rst_n(rst_n),
        .rsp_valid(icache_rsp_valid), .cut(pred_taken), .cut_slot(btb_slot),
        .mask(slot_mask)
    );

    // Predicted next address: hold without a response, else target or fall-through.
    always_comb begin
        if (!icache_rsp_valid) next_pc = pc_q;
        else if (pred_taken)   next_pc = btb_target;
        else                   next_pc = fall_pc;
    end

    // Redirect from the back end wins over the prediction.
    assign pc_d = redirect_valid ? redirect_pc : next_pc;

    // Fetch address register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= pc_d;
    end

    // R7: a redirect sets the fetch address on the next edge.
    p_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> icache_req_addr == $past(redirect_pc));
    // R2: an accepted group without a taken prediction steps by one group.
    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && icache_rsp_valid && !pred_taken) |=>
        icache_req_addr == $past(icache_req_addr) + ADDR_W'(GSTEP));
    // R8: without a response the fetch address holds.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && !icache_rsp_valid) |=> $stable(icache_req_addr));
endmodule

// File: tb/fetch_addr_sel_test.sv
// Bench fetch_addr_sel_test: sweeps every target buffer index through all
// counter states and slots, plus alias, stall, redirect and reset cases.
module fetch_addr_sel_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RST_PC = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redirect_valid = 1'b0;
    logic [31:0] redirect_pc = '0;
    logic [31:0] icache_req_addr;
    logic        icache_rsp_valid = 1'b0;
    logic [31:0] next_pc;
    logic [3:0]  slot_mask;
    logic        pred_taken;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic [1:0]  upd_slot = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model of the tables, kept per the requirement arithmetic.
    bit          m_valid [16];
    logic [23:0] m_tag   [16];
    logic [31:0] m_tgt   [16];
    int          m_slot  [16];
    int          m_ctr   [64];

    fetch_addr_sel uut (
        .clk(clk), .rst_n(rst_n),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .icache_req_addr(icache_req_addr), .icache_rsp_valid(icache_rsp_valid),
        .next_pc(next_pc), .slot_mask(slot_mask), .pred_taken(pred_taken),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target), .upd_slot(upd_slot)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic goto_pc(input logic [31:0] a);
        @(negedge clk);
        redirect_valid = 1'b1; redirect_pc = a; icache_rsp_valid = 1'b0;
        @(negedge clk);
        redirect_valid = 1'b0;
    endtask

    task automatic train(input logic [31:0] a, input bit tk, input logic [31:0] t, input int s);
        int bi, pi;
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = a; upd_taken = tk; upd_target = t; upd_slot = 2'(s);
        @(negedge clk);
        upd_valid = 1'b0;
        bi = int'(a[7:4]); pi = int'(a[9:4]);
        m_valid[bi] = 1; m_tag[bi] = a[31:8]; m_tgt[bi] = t; m_slot[bi] = s;
        if (tk && m_ctr[pi] < 3) m_ctr[pi]++;
        else if (!tk && m_ctr[pi] > 0) m_ctr[pi]--;
    endtask

    // Probe the combinational outputs at the current fetch address.
    task automatic probe(input string req, input logic [31:0] a);
        int bi, pi;
        bit hit, tk;
        logic [31:0] exp_next;
        logic [3:0]  exp_mask;
        bi = int'(a[7:4]); pi = int'(a[9:4]);
        hit = m_valid[bi] && (m_tag[bi] == a[31:8]);
        tk = hit && (m_ctr[pi] >= 2);
        exp_next = tk ? m_tgt[bi] : a + 32'd16;
        exp_mask = tk ? 4'((1 << (m_slot[bi] + 1)) - 1) : 4'hF;
        icache_rsp_valid = 1'b1;
        #1;
        chk({req, " pc"}, icache_req_addr, a);
        chk({req, " next"}, next_pc, exp_next);
        chk({req, " mask"}, {28'd0, slot_mask}, {28'd0, exp_mask});
        chk({req, " taken"}, {31'd0, pred_taken}, {31'd0, tk});
        icache_rsp_valid = 1'b0;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, t;
        for (int i = 0; i < 16; i++) m_valid[i] = 0;
        for (int i = 0; i < 64; i++) m_ctr[i] = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, sequential prediction everywhere.
        probe("R1 reset", RST_PC);

        for (int i = 0; i < 16; i++) begin
            a = 32'h0000_1000 + 32'(i * 16);
            t = 32'h0000_8000 + 32'(i * 64);
            goto_pc(a);
            probe("R2 miss", a);
            train(a, 1'b0, t, i % 4);
            probe("R4 hit not-taken", a);
            for (int k = 0; k < 4; k++) begin
                train(a, 1'b1, t, i % 4);
                probe("R5 R3 train up", a);
            end
            // R6: same index, different tag.
            goto_pc(a + 32'h100);
            probe("R6 alias", a + 32'h100);
            // R3: accepted fetch goes to the target on the next edge.
            goto_pc(a);
            @(negedge clk); icache_rsp_valid = 1'b1;
            @(negedge clk); icache_rsp_valid = 1'b0;
            chk("R3 next edge", icache_req_addr, t);
        end

        // R5: down training with saturation at zero.
        a = 32'h0000_1030;
        goto_pc(a);
        for (int k = 0; k < 4; k++) begin
            train(a, 1'b0, 32'h0000_80C0, 3);
            probe("R5 train down", a);
        end

        // R2: sequential step on an accepted miss.
        goto_pc(32'h0000_4000);
        @(negedge clk); icache_rsp_valid = 1'b1;
        @(negedge clk); icache_rsp_valid = 1'b0;
        chk("R2 next edge", icache_req_addr, 32'h0000_4010);

        // R8: stall holds address and empties mask.
        icache_rsp_valid = 1'b0;
        #1;
        chk("R8 mask", {28'd0, slot_mask}, 32'd0);
        chk("R8 next", next_pc, 32'h0000_4010);
        @(negedge clk); @(negedge clk);
        chk("R8 hold", icache_req_addr, 32'h0000_4010);

        // R7: redirect overrides a taken prediction with a response.
        goto_pc(32'h0000_1050);
        @(negedge clk);
        icache_rsp_valid = 1'b1; redirect_valid = 1'b1; redirect_pc = 32'h0000_3000;
        @(negedge clk);
        icache_rsp_valid = 1'b0; redirect_valid = 1'b0;
        chk("R7 redirect", icache_req_addr, 32'h0000_3000);

        // R9: update written while fetching elsewhere is seen next cycle.
        train(32'h0000_3000, 1'b1, 32'h0000_9000, 1);
        train(32'h0000_3000, 1'b1, 32'h0000_9000, 1);
        probe("R9 visible", 32'h0000_3000);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule